// File: doc/BRIEF.md
# Paired-Block Interrupt Controller

This block collects the interrupt sources of an eight-channel serial controller. The channels are grouped two to a block, which gives four blocks. Each block keeps an 8-bit status register and an 8-bit mask register. Status bits are set and cleared by one-cycle pulses from the channel logic. The blocks are merged in pairs onto two level-sensitive interrupt lines.

The host reaches the block through one byte-wide access port. The port has four address spaces: register, identification, acknowledge and memory. In register space the block decodes the 8-bit byte address into a block index, a channel index and a register offset. The offset is byte-swapped, because the host uses big-endian, odd-byte access. Status and mask share one offset: a read returns the status and a write loads the mask. An acknowledge read returns a programmable vector byte. That vector is written through the identification or memory space.

The access port takes one transfer in every cycle in which `acc_valid` is high and exerts no back-pressure, so it has no ready signal. Read data is combinational during the read cycle. Writes and source pulses take effect at the next rising clock edge.

Top module: `pair_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, all status, mask and vector registers are cleared and both interrupt lines are driven low; after release, a vector read returns 0x00 and every status read returns 0x00.
- R2: Within block b, channel 2b uses status bits 0 (transmit ready), 1 (receive ready) and 2 (break); channel 2b+1 uses bits 4, 5 and 6 for the same three sources; bits 3 and 7 always read 0.
- R3: A set pulse makes its status bit 1 at the next edge and a clear pulse makes it 0; when set and clear arrive in the same cycle, set wins.
- R4: A register-space read with offset `(addr & 0x1F) ^ 1` equal to 0x0B (address low bits 0x0A) returns the status of block `addr[7:5]`; a block index of 4 or more returns 0x00.
- R5: A register-space write at offset 0x0B loads the mask of block `addr[7:5]` and leaves its status unchanged; the mask cannot be read back.
- R6: Line 0 is high when `status & mask` is nonzero in block 0 or block 1, and line 1 follows blocks 2 and 3 in the same way; each line is registered and changes one cycle after the status or mask change.
- R7: A write to address 1 in identification space (1) or memory space (3) loads the vector; writes to other addresses or other spaces leave it unchanged.
- R8: An acknowledge-space (2) read at address 0 or 2 returns the vector; any other acknowledge address returns 0x00.
- R9: `dec_chan` equals `acc_addr[7:4]` and `dec_reg` equals `acc_addr[4:0] ^ 1`, continuously.
- R10: Register-space reads at any other offset return 0x00, and writes to them change no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 register, 1 identification, 2 acknowledge, 3 memory |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid during a read cycle, 0 otherwise |
| tx_set | input | 8 | Per-channel transmit-ready set pulses |
| tx_clr | input | 8 | Per-channel transmit-ready clear pulses |
| rx_set | input | 8 | Per-channel receive-ready set pulses |
| rx_clr | input | 8 | Per-channel receive-ready clear pulses |
| brk_set | input | 8 | Per-channel break set pulses |
| brk_clr | input | 8 | Per-channel break clear pulses |
| dec_chan | output | 4 | Decoded channel index for the channel registers |
| dec_reg | output | 5 | Decoded, byte-swapped register offset |
| irq_line | output | 2 | Level interrupt lines, one per block pair |

## Verification
The bench targets the byte swap. A decoder that left the offset unswapped would answer at 0x0B rather than 0x0A, so a status read would return zero and a mask write would land nowhere. The bench also checks the pairing. If line 0 merged blocks 0 and 2, or the odd-channel bits sat at the wrong nibble, a masked source in block 1 would raise the wrong line or none. It sends set and clear in the same cycle to catch a clear-wins priority, and it looks at the lines one cycle after a mask write to catch a combinational or two-stage path. Writes to the vector from the wrong address or the wrong space must leave the acknowledge value unchanged. A reset in the middle of the run must clear every register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Access spaces on the host port
  typedef enum logic [1:0] {
    SP_REG  = 2'd0,
    SP_ID   = 2'd1,
    SP_ACK  = 2'd2,
    SP_MEM  = 2'd3
  } space_e;

  // Source kinds per channel, also the bit offset inside a channel nibble
  localparam int unsigned SRC_TX  = 0;
  localparam int unsigned SRC_RX  = 1;
  localparam int unsigned SRC_BRK = 2;
  localparam int unsigned N_SRC   = 3;

  // Byte-swapped offset shared by status read and mask write
  localparam logic [4:0] OFF_STAT_MASK = 5'h0B;
  // Address that loads the vector in identification and memory spaces
  localparam logic [7:0] VEC_WR_ADDR   = 8'h01;

  // Status bit of a source for the even (0) or odd (1) channel of a block
  function automatic int unsigned stat_bit(input int unsigned odd, input int unsigned kind);
    return odd * 4 + kind;
  endfunction
endpackage

// File: rtl/pic_addr_dec.sv
module pic_addr_dec #(
  parameter int unsigned AW    = 8,
  parameter int unsigned N_BLK = 4,
  localparam int unsigned BW   = AW - 5,
  localparam int unsigned CW   = AW - 4
) (
  input  logic [AW-1:0] addr,
  output logic [BW-1:0] blk_idx,
  output logic [CW-1:0] chan_idx,
  output logic [4:0]    reg_off,
  output logic          blk_ok
);
  assign blk_idx  = addr[AW-1:5];
  assign chan_idx = addr[AW-1:4];
  assign reg_off  = addr[4:0] ^ 5'h01;
  assign blk_ok   = ({1'b0, blk_idx} < (BW+1)'(N_BLK));
endmodule

// File: rtl/pic_blk_regs.sv
module pic_blk_regs
  import pic_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    src_set,   // [2:0] even channel, [5:3] odd channel
  input  logic [5:0]    src_clr,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] mask_q
);
  logic [DW-1:0] stat_d;

  always_comb begin
    stat_d = '0;
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < N_SRC; k++) begin
        stat_d[stat_bit(h, k)] = src_set[h*N_SRC+k] |
                                 (stat_q[stat_bit(h, k)] & ~src_clr[h*N_SRC+k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/pic_line_merge.sv
module pic_line_merge #(
  parameter int unsigned N_BLK        = 4,
  parameter int unsigned BLK_PER_LINE = 2,
  localparam int unsigned N_LINE      = N_BLK / BLK_PER_LINE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BLK-1:0]  blk_pend,
  output logic [N_LINE-1:0] line_q
);
  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic any_pend;
    assign any_pend = |blk_pend[l*BLK_PER_LINE +: BLK_PER_LINE];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[l] <= 1'b0;
      else        line_q[l] <= any_pend;
    end
  end
endmodule

// File: rtl/pair_irq_ctrl.sv
module pair_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned AW           = 8,
  parameter int unsigned DW           = 8,
  parameter int unsigned N_BLK        = 4,
  parameter int unsigned BLK_PER_LINE = 2,
  localparam int unsigned N_CH        = N_BLK * 2,
  localparam int unsigned N_LINE      = N_BLK / BLK_PER_LINE,
  localparam int unsigned BW          = AW - 5,
  localparam int unsigned CW          = AW - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_space,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  input  logic [N_CH-1:0]   tx_set,
  input  logic [N_CH-1:0]   tx_clr,
  input  logic [N_CH-1:0]   rx_set,
  input  logic [N_CH-1:0]   rx_clr,
  input  logic [N_CH-1:0]   brk_set,
  input  logic [N_CH-1:0]   brk_clr,
  output logic [CW-1:0]     dec_chan,
  output logic [4:0]        dec_reg,
  output logic [N_LINE-1:0] irq_line
);
  logic [BW-1:0]       blk_idx;
  logic                blk_ok;
  logic [N_BLK*DW-1:0] stat_flat;
  logic [N_BLK*DW-1:0] mask_flat;
  logic [N_BLK-1:0]    blk_pend;
  logic [DW-1:0]       vec_q;

  logic rd_en, wr_en, hit_sm, ack_hit, vec_wr;
  assign rd_en   = acc_valid & ~acc_write;
  assign wr_en   = acc_valid &  acc_write;
  assign hit_sm  = (acc_space == SP_REG) && (dec_reg == OFF_STAT_MASK) && blk_ok;
  assign ack_hit = (acc_space == SP_ACK) && (acc_addr == AW'(0) || acc_addr == AW'(2));
  assign vec_wr  = wr_en && (acc_space == SP_ID || acc_space == SP_MEM) &&
                   (acc_addr == AW'(VEC_WR_ADDR));

  pic_addr_dec #(.AW(AW), .N_BLK(N_BLK)) u_dec (
    .addr     (acc_addr),
    .blk_idx  (blk_idx),
    .chan_idx (dec_chan),
    .reg_off  (dec_reg),
    .blk_ok   (blk_ok)
  );

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    logic [5:0] set_v, clr_v;
    logic       mwe;
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign set_v[h*N_SRC+SRC_TX]  = tx_set [2*b+h];
      assign set_v[h*N_SRC+SRC_RX]  = rx_set [2*b+h];
      assign set_v[h*N_SRC+SRC_BRK] = brk_set[2*b+h];
      assign clr_v[h*N_SRC+SRC_TX]  = tx_clr [2*b+h];
      assign clr_v[h*N_SRC+SRC_RX]  = rx_clr [2*b+h];
      assign clr_v[h*N_SRC+SRC_BRK] = brk_clr[2*b+h];
    end
    assign mwe = wr_en && hit_sm && (blk_idx == BW'(b));

    pic_blk_regs #(.DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_set    (set_v),
      .src_clr    (clr_v),
      .mask_we    (mwe),
      .mask_wdata (acc_wdata),
      .stat_q     (stat_flat[b*DW +: DW]),
      .mask_q     (mask_flat[b*DW +: DW])
    );
    assign blk_pend[b] = |(stat_flat[b*DW +: DW] & mask_flat[b*DW +: DW]);
  end

  pic_line_merge #(.N_BLK(N_BLK), .BLK_PER_LINE(BLK_PER_LINE)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_pend (blk_pend),
    .line_q   (irq_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_wr) vec_q <= acc_wdata;
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_en) begin
      if (hit_sm) begin
        for (int b = 0; b < N_BLK; b++) begin
          if (blk_idx == BW'(b)) acc_rdata = stat_flat[b*DW +: DW];
        end
      end else if (ack_hit) begin
        acc_rdata = vec_q;
      end
    end
  end
endmodule

// File: rtl/pair_irq_ctrl_chk.sv
module pair_irq_ctrl_chk #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned N_BLK  = 4,
  parameter int unsigned N_LINE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [1:0]        acc_space,
  input logic [AW-1:0]     acc_addr,
  input logic [DW-1:0]     acc_rdata,
  input logic [7:0]        tx_set,
  input logic [7:0]        rx_clr,
  input logic [7:0]        rx_set,
  input logic [AW-5:0]     dec_chan,
  input logic [4:0]        dec_reg,
  input logic [N_BLK*DW-1:0] stat_flat,
  input logic [N_BLK*DW-1:0] mask_flat,
  input logic [DW-1:0]     vec_q,
  input logic [N_LINE-1:0] irq_line
);
  // R6
  line0_follows_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_line[0] == $past(|(stat_flat[0 +: DW] & mask_flat[0 +: DW]) |
                                  |(stat_flat[DW +: DW] & mask_flat[DW +: DW])));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set[1] |=> stat_flat[5]);

  // R3
  tx_set_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set[0] |=> stat_flat[0]);

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr[0] && !rx_set[0]) |=> !stat_flat[1]);

  // R7
  vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_addr == AW'(1) && (acc_space == 2'd1 || acc_space == 2'd3))
    |=> $stable(vec_q));

  // R8
  ack_returns_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_space == 2'd2 && acc_addr == AW'(0)) |-> acc_rdata == vec_q);

  // R9
  decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_chan == acc_addr[AW-1:4] && dec_reg == {acc_addr[4:1], ~acc_addr[0]});

  // R2
  for (genvar b = 0; b < N_BLK; b++) begin : g_unused
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flat[b*DW+3] == 1'b0 && stat_flat[b*DW+7] == 1'b0);
  end
endmodule

bind pair_irq_ctrl pair_irq_ctrl_chk #(
  .AW(AW), .DW(DW), .N_BLK(N_BLK), .N_LINE(N_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_space (acc_space),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .tx_set    (tx_set),
  .rx_clr    (rx_clr),
  .rx_set    (rx_set),
  .dec_chan  (dec_chan),
  .dec_reg   (dec_reg),
  .stat_flat (stat_flat),
  .mask_flat (mask_flat),
  .vec_q     (vec_q),
  .irq_line  (irq_line)
);

// File: tb/tb_pair_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pair_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_space = '0;
  logic [7:0] acc_addr = '0, acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [7:0] tx_set = '0, tx_clr = '0, rx_set = '0, rx_clr = '0, brk_set = '0, brk_clr = '0;
  logic [3:0] dec_chan;
  logic [4:0] dec_reg;
  logic [1:0] irq_line;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk; // 200 MHz

  pair_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr),
    .brk_set(brk_set), .brk_clr(brk_clr), .dec_chan(dec_chan), .dec_reg(dec_reg),
    .irq_line(irq_line)
  );

  // Ops: 0 write, 1 read, 2 set pulse, 3 clear pulse
  // Fields: [39:36] op, [35:32] space or source kind (0 tx,1 rx,2 brk),
  //         [31:24] addr or channel, [23:16] wdata, [15:8] expected rdata, [7:0] expected lines
  localparam int NV = 27;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1, 4'd0, 8'h0A, 8'h00, 8'h01, 8'h00},
    {4'd0, 4'd0, 8'h0A, 8'h01, 8'h00, 8'h01},
    {4'd2, 4'd1, 8'h03, 8'h00, 8'h00, 8'h01},
    {4'd1, 4'd0, 8'h2A, 8'h00, 8'h20, 8'h01},
    {4'd0, 4'd0, 8'h6A, 8'h40, 8'h00, 8'h01},
    {4'd2, 4'd2, 8'h07, 8'h00, 8'h00, 8'h03},
    {4'd3, 4'd0, 8'h00, 8'h00, 8'h00, 8'h02},
    {4'd1, 4'd0, 8'h0A, 8'h00, 8'h00, 8'h02},
    {4'd3, 4'd2, 8'h07, 8'h00, 8'h00, 8'h00},
    {4'd0, 4'd1, 8'h01, 8'h5C, 8'h00, 8'h00},
    {4'd1, 4'd2, 8'h00, 8'h00, 8'h5C, 8'h00},
    {4'd1, 4'd2, 8'h02, 8'h00, 8'h5C, 8'h00},
    {4'd1, 4'd2, 8'h01, 8'h00, 8'h00, 8'h00},
    {4'd0, 4'd3, 8'h01, 8'hA7, 8'h00, 8'h00},
    {4'd1, 4'd2, 8'h00, 8'h00, 8'hA7, 8'h00},
    {4'd0, 4'd1, 8'h03, 8'h11, 8'h00, 8'h00},
    {4'd1, 4'd2, 8'h02, 8'h00, 8'hA7, 8'h00},
    {4'd0, 4'd0, 8'h0B, 8'hFF, 8'h00, 8'h00},
    {4'd2, 4'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    {4'd1, 4'd0, 8'h0B, 8'h00, 8'h00, 8'h00},
    {4'd1, 4'd0, 8'h0A, 8'h00, 8'h02, 8'h00},
    {4'd2, 4'd2, 8'h02, 8'h00, 8'h00, 8'h00},
    {4'd0, 4'd0, 8'h2A, 8'h04, 8'h00, 8'h01},
    {4'd1, 4'd0, 8'h8A, 8'h00, 8'h00, 8'h01},
    {4'd0, 4'd2, 8'h00, 8'h33, 8'h00, 8'h01},
    {4'd1, 4'd2, 8'h00, 8'h00, 8'hA7, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    acc_valid = 0; acc_write = 0; acc_space = 0; acc_addr = 0; acc_wdata = 0;
    tx_set = 0; tx_clr = 0; rx_set = 0; rx_clr = 0; brk_set = 0; brk_clr = 0;
  endtask

  task automatic pulse(input bit is_set, input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: if (is_set) tx_set[ch] = 1'b1;  else tx_clr[ch] = 1'b1;
      1: if (is_set) rx_set[ch] = 1'b1;  else rx_clr[ch] = 1'b1;
      default: if (is_set) brk_set[ch] = 1'b1; else brk_clr[ch] = 1'b1;
    endcase
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic wr(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_space = sp; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic rd(input logic [1:0] sp, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_space = sp; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    logic [7:0] r;
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    check("R1 lines in reset", {6'b0, irq_line}, 8'h00);
    rst_n = 1'b1;
    rd(2'd2, 8'h00, r); check("R1 vector after reset", r, 8'h00);
    rd(2'd0, 8'h0A, r); check("R1 status after reset", r, 8'h00);

    // Table walk: R2 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, f;
      logic [7:0] a, wd, er, el;
      {op, f, a, wd, er, el} = VEC[i];
      case (op)
        4'd0: wr(f[1:0], a, wd);
        4'd1: begin rd(f[1:0], a, r); check("R4/R8/R10 rdata", r, er); end
        4'd2: pulse(1, int'(f), int'(a));
        default: pulse(0, int'(f), int'(a));
      endcase
      @(negedge clk);
      check("R2/R6 lines", {6'b0, irq_line}, el);
    end

    // R9: decode outputs follow the address
    @(negedge clk); acc_addr = 8'h5B; #1;
    check("R9 channel", {4'b0, dec_chan}, 8'h05);
    check("R9 offset", {3'b0, dec_reg}, 8'h1A);
    clear_inputs();

    // R6: one-cycle latency after a mask write (block 3, line 1)
    pulse(1, 1, 6);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_space = 2'd0; acc_addr = 8'h6A; acc_wdata = 8'h02;
    @(negedge clk); clear_inputs();
    check("R6 line1 not yet", {6'b0, irq_line}, 8'h01);
    @(negedge clk);
    check("R6 line1 after one cycle", {6'b0, irq_line}, 8'h03);

    // R3: set and clear together, set wins (block 2 bit 0)
    @(negedge clk); tx_set[4] = 1; tx_clr[4] = 1;
    @(negedge clk); clear_inputs();
    rd(2'd0, 8'h4A, r); check("R3 set wins", r, 8'h01);
    pulse(0, 0, 4);
    rd(2'd0, 8'h4A, r); check("R3 clear", r, 8'h00);

    // R2: all sources of block 2, bits 3 and 7 stay 0
    @(negedge clk); tx_set[5:4] = 2'b11; rx_set[5:4] = 2'b11; brk_set[5:4] = 2'b11;
    @(negedge clk); clear_inputs();
    rd(2'd0, 8'h4A, r); check("R2 full layout", r, 8'h77);

    // R5: mask write does not alter status and is not read back
    wr(2'd0, 8'h4A, 8'hFF);
    rd(2'd0, 8'h4A, r); check("R5 status kept", r, 8'h77);
    @(negedge clk);
    check("R5 mask drives line1", {6'b0, irq_line}, 8'h03);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 lines low in reset", {6'b0, irq_line}, 8'h00);
    @(negedge clk); rst_n = 1;
    rd(2'd2, 8'h00, r); check("R1 vector cleared", r, 8'h00);
    rd(2'd0, 8'h4A, r); check("R1 status cleared", r, 8'h00);
    rd(2'd0, 8'h2A, r); check("R1 status blk1 cleared", r, 8'h00);
    pulse(1, 1, 3);
    @(negedge clk);
    check("R1 mask cleared", {6'b0, irq_line}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule